// File: doc/BRIEF.md
# Parallel-Port Disk Bridge Decoder

This block sits on the adapter side of a parallel-port-to-disk bridge. It watches the host's eight data lines and six control lines, both brought in through two-flop synchronisers. From the edges on those lines it picks out two kinds of primitive:

- **Function code:** two pulses of control bit 3 while bits [2:0] hold 5.
- **Value:** one rise of control bit 1 while bit 0 is set.

The current function code decides what a value means:

- **Function 1:** the value is an address byte.
- **Function 0:** the value is register-write data or block data.
- **Function 2:** the value is a connect-mode setting.

Register traffic leaves on a simple register bus with an index, a file/command select, write data, read data and one-cycle strobes. In nibble mode read data comes back on four status lines, low nibble first. In byte mode the block drives the whole byte onto the data lines while the host holds control bit 5.

A connect handshake must come first. A control pulse to 0xC with data 0 arms the link, and a pair of function-2 values then chooses the mode. Until that handshake completes, every primitive is ignored. The same control pulse with data 7 drops the link.

Top module: `ppide_decoder`

## Requirements
- R1: After reset the link is down: `pp_status` is 0, `pp_data_oe` is 0, and no `rb_wr` or `rb_rd` strobe occurs.
- R2: A control step from 0x4 to 0xC while data is 0x00, followed by two function-2 values 0x00 then 0x08, brings the link up in nibble mode.
- R3: The same arming step followed by function-2 values 0x08 then 0x09 brings the link up in byte mode. Arming again while linked restarts the handshake.
- R4: Any other function-2 pair leaves the link down. While the link is down, function and value primitives cause no bus strobe.
- R5: A value received under function 1 is the address byte. `rb_addr` equals bits [7:2] of it and `rb_cmd` equals bit 1 of it; the host sends register index × 4 + 1 for the register file and + 2 for the command set.
- R6: Outside block mode, values under function 0 are paired. The first value of a pair makes no write. The second makes exactly one `rb_wr` carrying that second value. A new address byte restarts the pairing.
- R7: When the address byte is 0x01 (block mode), every value under function 0 produces one `rb_wr` carrying that value.
- R8: In nibble mode each control step from 0x4 to 0x6 advances the status lines: first the low nibble of the read byte, then the high nibble, and so on alternately. A register read performs exactly one `rb_rd`.
- R9: In byte mode, control bit 5 set (0x26) drives the read byte on `pp_data_out` with `pp_data_oe` high. In nibble mode bit 5 never enables the data lines.
- R10: In block mode each byte handed to the host is fetched by its own `rb_rd`: after the high nibble in nibble mode, or after bit 5 falls in byte mode.
- R11: A control step from 0x4 to 0xC while data is 0x07 drops the link. Later primitives make no strobe, and the status and data-enable outputs return to 0.
- R12: `rb_wr` and `rb_rd` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Adapter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pp_data_in | input | 8 | Host data lines as seen by the adapter |
| pp_ctrl | input | 6 | Host control lines; bit 5 requests byte read-back |
| pp_data_out | output | 8 | Read byte driven toward the host |
| pp_data_oe | output | 1 | Enable for `pp_data_out` |
| pp_status | output | 4 | Status lines carrying the read nibble |
| rb_addr | output | 6 | Register index |
| rb_cmd | output | 1 | 1 selects the command set, 0 the register file |
| rb_wr | output | 1 | Register write strobe |
| rb_rd | output | 1 | Register read strobe; `rb_rdata` is taken in the same cycle |
| rb_wdata | output | 8 | Register write data |
| rb_rdata | input | 8 | Register read data |

## Verification
A wrong pairing bit shows up at the bus as a write that is missing or doubled, within about four cycles of the second value edge. A wrong address byte shows up on `rb_addr` and `rb_cmd` at once. A wrong nibble pointer or a stale read buffer shows up as a swapped or repeated nibble on `pp_status`, or a repeated byte on `pp_data_out`, about five cycles after the host's strobe edge. A link state that is wrong in either direction shows up as bus strobes where none are allowed, or no strobes where some are due, on the first transaction after the handshake.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  typedef enum logic [1:0] {
    LNK_IDLE  = 2'd0,
    LNK_ARMED = 2'd1,
    LNK_UP    = 2'd2
  } lnk_e;

  localparam int DIR_BIT  = 5;
  localparam int FN_XFER  = 0;
  localparam int FN_ADDR  = 1;
  localparam int FN_CONN  = 2;
  localparam int HS_ARM   = 0;
  localparam int HS_DROP  = 7;
  localparam int BLK_ADDR = 1;
endpackage

// File: rtl/ppi_sync.sv
module ppi_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/ppi_prim.sv
module ppi_prim #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] c,
  output logic          fn_stb,
  output logic          val_stb,
  output logic          nib_stb,
  output logic          brise,
  output logic          bfall,
  output logic          hs_stb
);
  import ppi_pkg::*;

  logic [CW-1:0] cp_q;
  logic [1:0]    cnt_q, cnt_n;
  logic          pat, up3;
  logic [3:0]    lo, lop;

  always_comb begin
    lo  = c[3:0];
    lop = cp_q[3:0];
    pat = (c[2:0] == 3'b101);
    up3 = c[3] & ~cp_q[3];

    fn_stb  = pat && up3 && (cnt_q == 2'd1);
    val_stb = (lo == 4'h7) && (lop == 4'h5);
    nib_stb = (lo == 4'h6) && (lop == 4'h4) && !c[DIR_BIT];
    brise   = c[DIR_BIT] & ~cp_q[DIR_BIT];
    bfall   = ~c[DIR_BIT] & cp_q[DIR_BIT];
    hs_stb  = (lo == 4'hC) && (lop == 4'h4);

    if (!pat)                      cnt_n = 2'd0;
    else if (up3 && cnt_q != 2'd2) cnt_n = cnt_q + 2'd1;
    else                           cnt_n = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_q  <= '0;
      cnt_q <= '0;
    end else begin
      cp_q  <= c;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/ppi_link.sv
module ppi_link #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fn_stb,
  input  logic          val_stb,
  input  logic          hs_stb,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] fn_code,
  output logic          link_up,
  output logic          wide
);
  import ppi_pkg::*;

  lnk_e          st_q, st_n;
  logic          wide_q, wide_n;
  logic [DW-1:0] fn_q, fn_n;
  logic [DW-1:0] prev_q, prev_n;
  logic          pv_q, pv_n;

  always_comb begin
    st_n   = st_q;
    wide_n = wide_q;
    prev_n = prev_q;
    pv_n   = pv_q;
    fn_n   = fn_stb ? d : fn_q;

    if (hs_stb && d == DW'(HS_DROP)) begin
      st_n = LNK_IDLE;
    end else if (hs_stb && d == DW'(HS_ARM)) begin
      st_n = LNK_ARMED;
      pv_n = 1'b0;
    end else if (val_stb && st_q == LNK_ARMED && fn_q == DW'(FN_CONN)) begin
      if (pv_q && prev_q == DW'(0) && d == DW'(8)) begin
        st_n   = LNK_UP;
        wide_n = 1'b0;
      end else if (pv_q && prev_q == DW'(8) && d == DW'(9)) begin
        st_n   = LNK_UP;
        wide_n = 1'b1;
      end
      pv_n   = 1'b1;
      prev_n = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LNK_IDLE;
      wide_q <= 1'b0;
      fn_q   <= '0;
      prev_q <= '0;
      pv_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      wide_q <= wide_n;
      fn_q   <= fn_n;
      prev_q <= prev_n;
      pv_q   <= pv_n;
    end
  end

  assign fn_code = fn_q;
  assign link_up = (st_q == LNK_UP);
  assign wide    = wide_q;
endmodule

// File: rtl/ppi_xfer.sv
module ppi_xfer #(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_up,
  input  logic             wide,
  input  logic [DW-1:0]    fn_code,
  input  logic [DW-1:0]    d,
  input  logic             dir_bit,
  input  logic             fn_stb,
  input  logic             val_stb,
  input  logic             nib_stb,
  input  logic             brise,
  input  logic             bfall,
  input  logic [DW-1:0]    rb_rdata,
  output logic [DW-3:0]    rb_addr,
  output logic             rb_cmd,
  output logic             rb_wr,
  output logic             rb_rd,
  output logic [DW-1:0]    rb_wdata,
  output logic [DW-1:0]    pp_data_out,
  output logic             pp_data_oe,
  output logic [DW/2-1:0]  pp_status
);
  import ppi_pkg::*;
  localparam int HW = DW / 2;

  logic [DW-1:0] addr_q, addr_n, buf_q, buf_n, wdat_q, wdat_n;
  logic          half_q, half_n, valid_q, valid_n;
  logic          ptr_q, ptr_n, hi_q, hi_n;
  logic          wr_q, wr_n, rd_q, rd_n;
  logic          blk;

  always_comb begin
    blk     = (addr_q == DW'(BLK_ADDR));
    addr_n  = addr_q;
    buf_n   = buf_q;
    wdat_n  = wdat_q;
    half_n  = half_q;
    valid_n = valid_q;
    ptr_n   = ptr_q;
    hi_n    = hi_q;
    wr_n    = 1'b0;
    rd_n    = 1'b0;

    if (!link_up) begin
      half_n  = 1'b0;
      valid_n = 1'b0;
      ptr_n   = 1'b0;
      hi_n    = 1'b0;
    end else begin
      if (fn_stb) begin
        valid_n = 1'b0;
        ptr_n   = 1'b0;
        hi_n    = 1'b0;
      end
      if (val_stb && fn_code == DW'(FN_ADDR)) begin
        addr_n  = d;
        half_n  = 1'b0;
        valid_n = 1'b0;
      end
      if (val_stb && fn_code == DW'(FN_XFER)) begin
        if (blk || half_q) begin
          wr_n   = 1'b1;
          wdat_n = d;
          half_n = 1'b0;
        end else begin
          half_n = 1'b1;
        end
      end
      if (rd_q) begin
        buf_n   = rb_rdata;
        valid_n = 1'b1;
      end
      if (!wide && nib_stb) begin
        if (!ptr_q) begin
          hi_n  = 1'b0;
          ptr_n = 1'b1;
          if (!valid_q && !rd_q) rd_n = 1'b1;
        end else begin
          hi_n  = 1'b1;
          ptr_n = 1'b0;
          if (blk) valid_n = 1'b0;
        end
      end
      if (wide && brise && !valid_q && !rd_q) rd_n = 1'b1;
      if (wide && bfall && blk) valid_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      buf_q   <= '0;
      wdat_q  <= '0;
      half_q  <= 1'b0;
      valid_q <= 1'b0;
      ptr_q   <= 1'b0;
      hi_q    <= 1'b0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      addr_q  <= addr_n;
      buf_q   <= buf_n;
      wdat_q  <= wdat_n;
      half_q  <= half_n;
      valid_q <= valid_n;
      ptr_q   <= ptr_n;
      hi_q    <= hi_n;
      wr_q    <= wr_n;
      rd_q    <= rd_n;
    end
  end

  assign rb_addr     = addr_q[DW-1:2];
  assign rb_cmd      = addr_q[1];
  assign rb_wr       = wr_q;
  assign rb_rd       = rd_q;
  assign rb_wdata    = wdat_q;
  assign pp_data_out = buf_q;
  assign pp_data_oe  = link_up & wide & dir_bit;
  assign pp_status   = (link_up && !wide) ? (hi_q ? buf_q[DW-1:HW] : buf_q[HW-1:0])
                                          : '0;
endmodule

// File: rtl/ppide_decoder.sv
module ppide_decoder #(
  parameter int DATA_W      = 8,
  parameter int CTRL_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   pp_data_in,
  input  logic [CTRL_W-1:0]   pp_ctrl,
  output logic [DATA_W-1:0]   pp_data_out,
  output logic                pp_data_oe,
  output logic [DATA_W/2-1:0] pp_status,
  output logic [DATA_W-3:0]   rb_addr,
  output logic                rb_cmd,
  output logic                rb_wr,
  output logic                rb_rd,
  output logic [DATA_W-1:0]   rb_wdata,
  input  logic [DATA_W-1:0]   rb_rdata
);
  import ppi_pkg::*;

  logic [DATA_W-1:0] d_s, fn_code;
  logic [CTRL_W-1:0] c_s;
  logic fn_stb, val_stb, nib_stb, brise, bfall, hs_stb;
  logic link_up, wide;

  ppi_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_dsync (
    .clk(clk), .rst_n(rst_n), .din(pp_data_in), .dout(d_s));

  ppi_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_csync (
    .clk(clk), .rst_n(rst_n), .din(pp_ctrl), .dout(c_s));

  ppi_prim #(.CW(CTRL_W)) u_prim (
    .clk(clk), .rst_n(rst_n), .c(c_s),
    .fn_stb(fn_stb), .val_stb(val_stb), .nib_stb(nib_stb),
    .brise(brise), .bfall(bfall), .hs_stb(hs_stb));

  ppi_link #(.DW(DATA_W)) u_link (
    .clk(clk), .rst_n(rst_n), .fn_stb(fn_stb), .val_stb(val_stb),
    .hs_stb(hs_stb), .d(d_s), .fn_code(fn_code),
    .link_up(link_up), .wide(wide));

  ppi_xfer #(.DW(DATA_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .wide(wide),
    .fn_code(fn_code), .d(d_s), .dir_bit(c_s[DIR_BIT]),
    .fn_stb(fn_stb), .val_stb(val_stb), .nib_stb(nib_stb),
    .brise(brise), .bfall(bfall), .rb_rdata(rb_rdata),
    .rb_addr(rb_addr), .rb_cmd(rb_cmd), .rb_wr(rb_wr), .rb_rd(rb_rd),
    .rb_wdata(rb_wdata), .pp_data_out(pp_data_out),
    .pp_data_oe(pp_data_oe), .pp_status(pp_status));
endmodule

// File: rtl/ppi_chk.sv
module ppi_chk #(
  parameter int NW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rb_wr,
  input logic          rb_rd,
  input logic          pp_data_oe,
  input logic [NW-1:0] pp_status,
  input logic          link_up,
  input logic          wide
);
  assert_wr_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rb_wr |=> !rb_wr);

  assert_rd_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rb_rd |=> !rb_rd);

  assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(rb_wr && rb_rd));

  assert_quiet_unlinked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |-> (!rb_wr && !rb_rd && !pp_data_oe && pp_status == '0));

  assert_oe_byte_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pp_data_oe |-> wide);

  assert_drop_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_up) |=> !rb_wr && !pp_data_oe);
endmodule

bind ppide_decoder ppi_chk #(.NW(DATA_W/2)) u_chk (
  .clk(clk), .rst_n(rst_n), .rb_wr(rb_wr), .rb_rd(rb_rd),
  .pp_data_oe(pp_data_oe), .pp_status(pp_status),
  .link_up(link_up), .wide(wide));

// File: tb/tb_ppide_decoder.sv
`timescale 1ns/1ps
module tb_ppide_decoder;
  localparam int HOLD = 8;
  // {is_read, cont, regr[5:0], value[7:0]}
  localparam logic [15:0] VEC [6] = '{16'h025A, 16'h8200, 16'h46C3,
                                      16'hC600, 16'h07FF, 16'h8100};

  logic       clk, rst_n;
  logic [7:0] pp_data, pp_data_out, rb_wdata, rb_rdata;
  logic [5:0] pp_ctrl, rb_addr;
  logic [3:0] pp_status;
  logic       pp_data_oe, rb_cmd, rb_wr, rb_rd;

  int         checks = 0, errors = 0;
  bit         done = 0;
  int         wr_cnt = 0, rd_evt = 0;
  logic [7:0] rd_cnt = 8'd0;
  logic [5:0] last_addr;
  logic       last_cmd;
  logic [7:0] last_data;

  ppide_decoder dut (
    .clk(clk), .rst_n(rst_n), .pp_data_in(pp_data), .pp_ctrl(pp_ctrl),
    .pp_data_out(pp_data_out), .pp_data_oe(pp_data_oe), .pp_status(pp_status),
    .rb_addr(rb_addr), .rb_cmd(rb_cmd), .rb_wr(rb_wr), .rb_rd(rb_rd),
    .rb_wdata(rb_wdata), .rb_rdata(rb_rdata));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // register model: value depends on address and on how many reads so far
  assign rb_rdata = {rb_cmd, rb_addr, 1'b0} ^ 8'h3C ^ rd_cnt;

  always @(posedge clk) begin
    if (rb_wr) begin
      wr_cnt    <= wr_cnt + 1;
      last_addr <= rb_addr;
      last_cmd  <= rb_cmd;
      last_data <= rb_wdata;
    end
    if (rb_rd) begin
      rd_cnt <= rd_cnt + 8'd1;
      rd_evt <= rd_evt + 1;
    end
  end

  function automatic logic [7:0] model(input logic cont, input logic [5:0] regr,
                                       input logic [7:0] cnt);
    return {cont, regr, 1'b0} ^ 8'h3C ^ cnt;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setc(input logic [5:0] v);
    @(negedge clk); pp_ctrl = v;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic setd(input logic [7:0] v);
    @(negedge clk); pp_data = v;
  endtask

  task automatic op(input logic [7:0] f);
    setc(6'h04); setd(f); setc(6'h05); setc(6'h0D);
    setc(6'h05); setc(6'h0D); setc(6'h05); setc(6'h04);
  endtask

  task automatic vl(input logic [7:0] v);
    setc(6'h04); setd(v); setc(6'h05); setc(6'h07); setc(6'h05); setc(6'h04);
  endtask

  task automatic connect(input logic [7:0] a, input logic [7:0] b);
    setc(6'h04); setd(8'h00); setc(6'h0C); setc(6'h04);
    setc(6'h06); setc(6'h04); setc(6'h06); setc(6'h04);
    op(8'd2); vl(a); op(8'd2); vl(b);
  endtask

  task automatic disconnect();
    setc(6'h04); setd(8'h07); setc(6'h04); setc(6'h0C); setc(6'h04);
  endtask

  task automatic reg_write(input logic cont, input logic [5:0] regr, input logic [7:0] v);
    op(8'd1); vl({regr, cont ? 2'b10 : 2'b01});
    op(8'd0); vl(v); op(8'd0); vl(v);
  endtask

  task automatic nib_read(output logic [7:0] b);
    logic [3:0] l, h;
    setc(6'h04); setc(6'h06); l = pp_status;
    setc(6'h04); setc(6'h06); h = pp_status;
    setc(6'h04);
    b = {h, l};
  endtask

  task automatic byte_read(output logic [7:0] b, output logic oe);
    setc(6'h04); setc(6'h26); b = pp_data_out; oe = pp_data_oe;
    setc(6'h04);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b, exp;
    logic [7:0] snap;
    logic       oe;
    int         w0, r0;

    rst_n = 1'b0; pp_ctrl = 6'h04; pp_data = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(pp_status == 4'h0 && !pp_data_oe, "R1 idle outputs", {pp_data_oe, pp_status}, 0);
    chk(wr_cnt == 0 && rd_evt == 0, "R1 no strobes", wr_cnt + rd_evt, 0);

    // R4 unlinked and bad handshake pair ignore traffic
    reg_write(1'b0, 6'd3, 8'h11);
    chk(wr_cnt == 0, "R4 write while unlinked", wr_cnt, 0);
    connect(8'h08, 8'h08);
    reg_write(1'b0, 6'd3, 8'h11);
    chk(wr_cnt == 0, "R4 write after bad pair", wr_cnt, 0);

    // R2 nibble-mode connect, then table of register transactions (R5 R6 R8)
    connect(8'h00, 8'h08);
    for (int i = 0; i < 6; i++) begin
      logic       is_rd, cont;
      logic [5:0] regr;
      logic [7:0] val;
      {is_rd, cont, regr, val} = VEC[i];
      w0 = wr_cnt; r0 = rd_evt;
      if (!is_rd) begin
        reg_write(cont, regr, val);
        chk(wr_cnt == w0 + 1, "R6 one write per pair", wr_cnt - w0, 1);
        chk(last_addr == regr && last_cmd == cont, "R5 address decode",
            {last_cmd, last_addr}, {cont, regr});
        chk(last_data == val, "R6 write data", last_data, val);
      end else begin
        op(8'd1); vl({regr, cont ? 2'b10 : 2'b01}); op(8'd0);
        snap = rd_cnt;
        nib_read(b);
        exp = model(cont, regr, snap);
        chk(b == exp, "R8 nibble order", b, exp);
        nib_read(b);
        chk(b == exp, "R8 repeated nibbles", b, exp);
        chk(rd_evt == r0 + 1, "R8 single fetch", rd_evt - r0, 1);
      end
    end

    // R6 first value alone must not write
    w0 = wr_cnt;
    op(8'd1); vl({6'd5, 2'b01}); op(8'd0); vl(8'h77);
    chk(wr_cnt == w0, "R6 first value no write", wr_cnt - w0, 0);
    op(8'd0); vl(8'h77);
    chk(wr_cnt == w0 + 1 && last_data == 8'h77, "R6 second value commits", wr_cnt - w0, 1);

    // R9 bit 5 does not enable data lines in nibble mode
    byte_read(b, oe);
    chk(!oe, "R9 no drive in nibble mode", oe, 0);

    // R10 block read in nibble mode
    op(8'd1); vl(8'h01); op(8'd0);
    r0 = rd_evt; snap = rd_cnt;
    for (int k = 0; k < 3; k++) begin
      nib_read(b);
      exp = 8'h3C ^ (snap + 8'(k));
      chk(b == exp, "R10 nibble block byte", b, exp);
    end
    chk(rd_evt == r0 + 3, "R10 fetch per byte", rd_evt - r0, 3);

    // R3 byte-mode reconnect and register read
    connect(8'h08, 8'h09);
    op(8'd1); vl({6'd4, 2'b10}); op(8'd0);
    snap = rd_cnt;
    byte_read(b, oe);
    exp = model(1'b1, 6'd4, snap);
    chk(oe, "R9 drive in byte mode", oe, 1);
    chk(b == exp, "R3 byte read value", b, exp);
    byte_read(b, oe);
    chk(b == exp, "R9 register byte repeat", b, exp);

    // R7 block write stream
    op(8'd1); vl(8'h01); op(8'd0);
    w0 = wr_cnt;
    for (int k = 0; k < 4; k++) begin
      setc(6'h05); setd(8'hA0 + 8'(k)); setc(6'h07);
    end
    setc(6'h04);
    chk(wr_cnt == w0 + 4, "R7 one write per value", wr_cnt - w0, 4);
    chk(last_data == 8'hA3 && last_addr == 6'd0 && !last_cmd, "R7 last block byte",
        last_data, 8'hA3);

    // R10 block read in byte mode
    op(8'd1); vl(8'h01); op(8'd0);
    r0 = rd_evt; snap = rd_cnt;
    for (int k = 0; k < 3; k++) begin
      byte_read(b, oe);
      exp = 8'h3C ^ (snap + 8'(k));
      chk(b == exp && oe, "R10 byte block byte", b, exp);
    end
    chk(rd_evt == r0 + 3, "R10 byte fetch per byte", rd_evt - r0, 3);

    // R11 disconnect
    disconnect();
    w0 = wr_cnt;
    reg_write(1'b0, 6'd2, 8'h42);
    chk(wr_cnt == w0, "R11 no write after drop", wr_cnt - w0, 0);
    byte_read(b, oe);
    chk(!oe && pp_status == 4'h0, "R11 outputs idle after drop", {oe, pp_status}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule